// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block is the presentation stage that sits in front of a single processor in an interrupt fabric. It keeps five pieces of state: the processor's current priority threshold, the priority of a pending inter-processor request, the number of the source that is pending right now, that source's priority, and a flag that records a delivery it had to refuse. Priorities follow the convention that a lower number is more favoured, and 0xFF means nothing is pending. The interrupt line to the processor is raised whenever a pending source is more favoured than the current threshold.

Source controllers offer deliveries of a source number at a priority. The presenter takes the delivery only when it beats the threshold, the inter-processor request priority and whatever is already pending. The source it displaces is handed back on the reject port so that its controller can try again. A refusal sets the flag, and a later lowering of the threshold, or a move of the inter-processor priority to a less favoured value, turns that flag into a one-cycle resend request. The processor drives four single-cycle commands: accept, set threshold, set inter-processor priority and end-of-interrupt. The end-of-interrupt command forwards the finished source to the source side.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0, the inter-processor priority is 0xFF, the pending priority is 0xFF, the pending source is 0 and the resend flag is clear; irqOut is low and an accept returns 0x00000000.
- R2: irqOut is high exactly when the pending source is non-zero and its priority is numerically lower than the threshold.
- R3: A delivery at priority p is taken (dlvAccepted pulses one cycle later) only when p is lower than the threshold, the inter-processor priority and the pending priority; the source and p then become the pending pair.
- R4: A delivery that is not taken pulses dlvRefused one cycle later and sets the resend flag.
- R5: A displaced source is reported one cycle later on rejValid/rejSrc, except that a displaced 0 or the reserved inter-processor source number 2 is never reported.
- R6: Accept (cmdOp 0) returns acceptWord = threshold in bits 31:24 and pending source in bits 23:0, valid one cycle later; when the pending source was non-zero the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source 0, otherwise the state is unchanged.
- R7: Set inter-processor priority (cmdOp 1 is threshold, cmdOp 2 is this command, value in cmdData bits 7:0): when the new value is below the threshold and not above the pending priority, the old pending source is rejected and source 2 becomes pending at the new value.
- R8: When set inter-processor priority makes the value numerically larger than before, resendReq pulses if the resend flag was set, and the flag is cleared.
- R9: Setting the threshold to a larger value loads it, makes source 2 pending at the inter-processor priority when that priority is below the new threshold and not above the pending priority, and turns a set resend flag into a resendReq pulse while clearing it.
- R10: Setting the threshold to a smaller value rejects the pending source when the new value is not above the pending priority, then clears the pending source and sets the pending priority to 0xFF; setting an equal value changes nothing and raises no pulse.
- R11: End-of-interrupt (cmdOp 3) applies cmdData bits 31:24 through the threshold-raising path of R9 and forwards bits 23:0 on eoiValid/eoiSrc one cycle later, unless they equal 2.
- R12: When a command and a delivery arrive in the same cycle, the delivery is judged against the state left by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Processor command strobe |
| cmdOp | input | 2 | Command: 0 accept, 1 set threshold, 2 set inter-processor priority, 3 end-of-interrupt |
| cmdData | input | 32 | Command operand: priority in bits 7:0, or priority 31:24 and source 23:0 for end-of-interrupt |
| dlvValid | input | 1 | Delivery attempt strobe |
| dlvSrc | input | 24 | Offered source number |
| dlvPrio | input | 8 | Offered priority |
| dlvAccepted | output | 1 | Delivery was taken |
| dlvRefused | output | 1 | Delivery was refused |
| irqOut | output | 1 | Interrupt request to the processor |
| rejValid | output | 1 | A displaced source is being returned |
| rejSrc | output | 24 | Displaced source number |
| resendReq | output | 1 | Ask the source side to resend refused deliveries |
| acceptValid | output | 1 | acceptWord holds an accept result |
| acceptWord | output | 32 | Threshold and pending source captured by accept |
| eoiValid | output | 1 | End-of-interrupt forwarded to the source side |
| eoiSrc | output | 24 | Source whose handling finished |

## Verification
The bench builds the block with its default parameters: 8-bit priorities, 24-bit source numbers and inter-processor source number 2. Those values make the 32-bit accept and end-of-interrupt word layout directly checkable, and they let directed sequences reach both the suppressed reject of source 2 and real rejects of ordinary sources. Same-cycle command and delivery pairs are chosen so that the opposite ordering would give a different verdict, which exposes the processing order.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_CPPR = 2'd1,
    OP_SET_MFRR = 2'd2,
    OP_EOI      = 2'd3
  } cmdOp_e;

  // Strobes from control to datapath; at most one command path per cycle,
  // except eoi which rides on lowerCppr.
  typedef struct packed {
    logic accept;
    logic lowerCppr;
    logic raiseCppr;
    logic setMfrr;
    logic eoi;
  } cmdStrobe_t;

endpackage

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irqp_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [PRIO_W-1:0] cmdPrio,
  input  logic [PRIO_W-1:0] curCppr,
  output cmdStrobe_t        strobe
);

  cmdOp_e op;

  always_comb begin
    op     = cmdOp_e'(cmdOp);
    strobe = '0;
    if (cmdValid) begin
      unique case (op)
        OP_ACCEPT:   strobe.accept = 1'b1;
        OP_SET_CPPR: begin
          strobe.lowerCppr = (cmdPrio > curCppr);
          strobe.raiseCppr = (cmdPrio < curCppr);
        end
        OP_SET_MFRR: strobe.setMfrr = 1'b1;
        OP_EOI: begin
          strobe.lowerCppr = 1'b1;
          strobe.eoi       = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/irqp_dpath.sv
module irqp_dpath
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmdStrobe_t              strobe,
  input  logic [PRIO_W-1:0]       cmdPrio,
  input  logic [SRC_W-1:0]        cmdSrc,
  input  logic                    dlvValid,
  input  logic [SRC_W-1:0]        dlvSrc,
  input  logic [PRIO_W-1:0]       dlvPrio,
  output logic [PRIO_W-1:0]       curCppr,
  output logic                    dlvAccepted,
  output logic                    dlvRefused,
  output logic                    irqOut,
  output logic                    rejValid,
  output logic [SRC_W-1:0]        rejSrc,
  output logic                    resendReq,
  output logic                    acceptValid,
  output logic [PRIO_W+SRC_W-1:0] acceptWord,
  output logic                    eoiValid,
  output logic [SRC_W-1:0]        eoiSrc
);

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic [PRIO_W-1:0] cppr, mfrr, pendPrio;
  logic [SRC_W-1:0]  xisr;
  logic              needResend;

  // state after the command stage
  logic [PRIO_W-1:0] cCppr, cMfrr, cPend;
  logic [SRC_W-1:0]  cXisr;
  logic              cNeed;
  logic [SRC_W-1:0]  rejCmd;
  logic              resendNow;
  // state after the delivery stage
  logic [PRIO_W-1:0] nPend;
  logic [SRC_W-1:0]  nXisr;
  logic              nNeed;
  logic [SRC_W-1:0]  rejDlv;
  logic              dlvOk;
  logic              cmdRejShow, dlvRejShow;

  function automatic logic reportable(input logic [SRC_W-1:0] s);
    return (s != '0) && (s != IPI_NUM);
  endfunction

  // command stage
  always_comb begin
    cCppr     = cppr;
    cMfrr     = mfrr;
    cPend     = pendPrio;
    cXisr     = xisr;
    cNeed     = needResend;
    rejCmd    = '0;
    resendNow = 1'b0;
    if (strobe.accept && (xisr != '0)) begin
      cCppr = pendPrio;
      cPend = PRIO_NONE;
      cXisr = '0;
    end
    if (strobe.lowerCppr) begin
      cCppr = cmdPrio;
      if ((mfrr < cmdPrio) && (mfrr <= pendPrio)) begin
        cPend = mfrr;
        cXisr = IPI_NUM;
      end
      resendNow = needResend;
      cNeed     = 1'b0;
    end
    if (strobe.raiseCppr) begin
      cCppr = cmdPrio;
      if (cmdPrio <= pendPrio) begin
        rejCmd = xisr;
        cXisr  = '0;
        cPend  = PRIO_NONE;
      end
    end
    if (strobe.setMfrr) begin
      cMfrr = cmdPrio;
      if ((cmdPrio < cppr) && (cmdPrio <= pendPrio)) begin
        rejCmd = xisr;
        cPend  = cmdPrio;
        cXisr  = IPI_NUM;
      end
      if (cmdPrio > mfrr) begin
        resendNow = needResend;
        cNeed     = 1'b0;
      end
    end
  end

  // delivery stage, judged on the post-command state
  always_comb begin
    nPend  = cPend;
    nXisr  = cXisr;
    nNeed  = cNeed;
    rejDlv = '0;
    dlvOk  = dlvValid && (dlvPrio < cCppr) && (dlvPrio < cMfrr) && (dlvPrio < cPend);
    if (dlvOk) begin
      rejDlv = cXisr;
      nXisr  = dlvSrc;
      nPend  = dlvPrio;
    end else if (dlvValid) begin
      nNeed = 1'b1;
    end
    cmdRejShow = reportable(rejCmd);
    dlvRejShow = reportable(rejDlv);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cppr        <= '0;
      mfrr        <= PRIO_NONE;
      pendPrio    <= PRIO_NONE;
      xisr        <= '0;
      needResend  <= 1'b0;
      dlvAccepted <= 1'b0;
      dlvRefused  <= 1'b0;
      rejValid    <= 1'b0;
      rejSrc      <= '0;
      resendReq   <= 1'b0;
      acceptValid <= 1'b0;
      acceptWord  <= '0;
      eoiValid    <= 1'b0;
      eoiSrc      <= '0;
    end else begin
      cppr        <= cCppr;
      mfrr        <= cMfrr;
      pendPrio    <= nPend;
      xisr        <= nXisr;
      needResend  <= nNeed;
      dlvAccepted <= dlvOk;
      dlvRefused  <= dlvValid && !dlvOk;
      rejValid    <= cmdRejShow || dlvRejShow;
      rejSrc      <= cmdRejShow ? rejCmd : (dlvRejShow ? rejDlv : '0);
      resendReq   <= resendNow;
      acceptValid <= strobe.accept;
      if (strobe.accept) acceptWord <= WORD_W'({cppr, xisr});
      eoiValid    <= strobe.eoi && (cmdSrc != IPI_NUM);
      if (strobe.eoi) eoiSrc <= cmdSrc;
    end
  end

  assign curCppr = cppr;
  assign irqOut  = (xisr != '0) && (pendPrio < cppr);

  // R5
  rej_reportable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejValid |-> ((rejSrc != '0) && (rejSrc != IPI_NUM)));

  // R4
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvRefused |-> needResend);

  // R3
  dlv_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dlvAccepted && dlvRefused));

  // R11
  eoi_not_ipi_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid |-> (eoiSrc != IPI_NUM));

  // R6
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && (xisr != '0) && !dlvValid) |=> ((xisr == '0) && (pendPrio == PRIO_NONE)));

  // R7
  mfrr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setMfrr |=> (mfrr == $past(mfrr)));

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdOp,
  input  logic [PRIO_W+SRC_W-1:0] cmdData,
  input  logic                    dlvValid,
  input  logic [SRC_W-1:0]        dlvSrc,
  input  logic [PRIO_W-1:0]       dlvPrio,
  output logic                    dlvAccepted,
  output logic                    dlvRefused,
  output logic                    irqOut,
  output logic                    rejValid,
  output logic [SRC_W-1:0]        rejSrc,
  output logic                    resendReq,
  output logic                    acceptValid,
  output logic [PRIO_W+SRC_W-1:0] acceptWord,
  output logic                    eoiValid,
  output logic [SRC_W-1:0]        eoiSrc
);

  localparam int WORD_W = PRIO_W + SRC_W;

  cmdStrobe_t        strobe;
  logic [PRIO_W-1:0] cmdPrio;
  logic [SRC_W-1:0]  cmdSrc;
  logic [PRIO_W-1:0] curCppr;

  // end-of-interrupt carries priority in the top field; other commands low bits
  assign cmdPrio = (cmdOp == 2'd3) ? cmdData[WORD_W-1:SRC_W] : cmdData[PRIO_W-1:0];
  assign cmdSrc  = cmdData[SRC_W-1:0];

  irqp_ctrl #(.PRIO_W(PRIO_W)) i_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdPrio  (cmdPrio),
    .curCppr  (curCppr),
    .strobe   (strobe)
  );

  irqp_dpath #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdPrio     (cmdPrio),
    .cmdSrc      (cmdSrc),
    .dlvValid    (dlvValid),
    .dlvSrc      (dlvSrc),
    .dlvPrio     (dlvPrio),
    .curCppr     (curCppr),
    .dlvAccepted (dlvAccepted),
    .dlvRefused  (dlvRefused),
    .irqOut      (irqOut),
    .rejValid    (rejValid),
    .rejSrc      (rejSrc),
    .resendReq   (resendReq),
    .acceptValid (acceptValid),
    .acceptWord  (acceptWord),
    .eoiValid    (eoiValid),
    .eoiSrc      (eoiSrc)
  );

endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [31:0] cmdData = '0;
  logic        dlvValid = 1'b0;
  logic [23:0] dlvSrc = '0;
  logic [7:0]  dlvPrio = '0;
  logic        dlvAccepted, dlvRefused, irqOut, rejValid, resendReq;
  logic        acceptValid, eoiValid;
  logic [23:0] rejSrc, eoiSrc;
  logic [31:0] acceptWord;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  irq_presenter i_irq_presenter (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .dlvValid(dlvValid), .dlvSrc(dlvSrc), .dlvPrio(dlvPrio),
    .dlvAccepted(dlvAccepted), .dlvRefused(dlvRefused), .irqOut(irqOut),
    .rejValid(rejValid), .rejSrc(rejSrc), .resendReq(resendReq),
    .acceptValid(acceptValid), .acceptWord(acceptWord),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // apply inputs, clock once, sample just after the edge, then idle inputs
  task automatic cycle(input logic cv, input logic [1:0] op, input logic [31:0] d,
                       input logic dv, input logic [23:0] s, input logic [7:0] p);
    cmdValid = cv; cmdOp = op; cmdData = d;
    dlvValid = dv; dlvSrc = s; dlvPrio = p;
    @(posedge clk); #1;
    cmdValid = 1'b0; dlvValid = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    cycle(1'b1, op, d, 1'b0, '0, '0);
  endtask

  task automatic dlv(input logic [23:0] s, input logic [7:0] p);
    cycle(1'b0, 2'd0, '0, 1'b1, s, p);
  endtask

  task automatic testReset();
    chk("R1", "irqOut", {31'd0, irqOut}, 32'd0);
    cmd(2'd0, '0);
    chk("R1", "acceptValid", {31'd0, acceptValid}, 32'd1);
    chk("R1", "acceptWord", acceptWord, 32'h0000_0000);
    // refusal at reset: threshold 0 beats everything
    dlv(24'h10, 8'h01);
    chk("R1", "refused at cppr 0", {31'd0, dlvRefused}, 32'd1);
    cmd(2'd1, 32'hFF);  // lower threshold, flag turns into resend
    chk("R9", "resend on lower", {31'd0, resendReq}, 32'd1);
  endtask

  task automatic testDeliver();
    dlv(24'h100, 8'h05);
    chk("R3", "accepted", {31'd0, dlvAccepted}, 32'd1);
    chk("R2", "irqOut high", {31'd0, irqOut}, 32'd1);
    chk("R5", "no reject of empty", {31'd0, rejValid}, 32'd0);
    dlv(24'h200, 8'h03);
    chk("R3", "accepted better", {31'd0, dlvAccepted}, 32'd1);
    chk("R5", "reject valid", {31'd0, rejValid}, 32'd1);
    chk("R5", "reject src", {8'd0, rejSrc}, 32'h100);
    dlv(24'h300, 8'h04);
    chk("R4", "refused", {31'd0, dlvRefused}, 32'd1);
    chk("R4", "no accept", {31'd0, dlvAccepted}, 32'd0);
  endtask

  task automatic testAccept();
    cmd(2'd0, '0);
    chk("R6", "word", acceptWord, 32'hFF00_0200);
    chk("R6", "irqOut low", {31'd0, irqOut}, 32'd0);
    cmd(2'd0, '0);
    chk("R6", "empty word keeps cppr", acceptWord, 32'h0300_0000);
  endtask

  task automatic testEoi();
    cmd(2'd3, 32'hFF00_0200);
    chk("R11", "eoi forwarded", {31'd0, eoiValid}, 32'd1);
    chk("R11", "eoi src", {8'd0, eoiSrc}, 32'h200);
    chk("R9", "resend from flag", {31'd0, resendReq}, 32'd1);
    cmd(2'd1, 32'hFF);
    chk("R10", "equal no resend", {31'd0, resendReq}, 32'd0);
    cmd(2'd0, '0);
    chk("R10", "equal keeps state", acceptWord, 32'hFF00_0000);
  endtask

  task automatic testIpi();
    cmd(2'd2, 32'h06);
    chk("R7", "ipi raises irq", {31'd0, irqOut}, 32'd1);
    chk("R5", "empty not rejected", {31'd0, rejValid}, 32'd0);
    cmd(2'd0, '0);
    chk("R7", "ipi pending word", acceptWord, 32'hFF00_0002);
    cmd(2'd3, 32'hFF00_0002);
    chk("R11", "ipi eoi not forwarded", {31'd0, eoiValid}, 32'd0);
    chk("R9", "ipi reinserted", {31'd0, irqOut}, 32'd1);
    cmd(2'd2, 32'hFF);
    chk("R8", "no resend without flag", {31'd0, resendReq}, 32'd0);
    cmd(2'd0, '0);
    chk("R9", "ipi still pending", acceptWord, 32'hFF00_0002);
    cmd(2'd1, 32'hFF);
    chk("R9", "no ipi with mfrr ff", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic testMfrrResend();
    cmd(2'd2, 32'h04);
    dlv(24'h50, 8'h05);
    chk("R4", "refused by mfrr", {31'd0, dlvRefused}, 32'd1);
    cmd(2'd2, 32'h08);
    chk("R8", "resend on increase", {31'd0, resendReq}, 32'd1);
    cmd(2'd2, 32'h09);
    chk("R8", "flag cleared", {31'd0, resendReq}, 32'd0);
    cmd(2'd1, 32'h04);  // raise: 4 <= pend 4, rejects IPI silently
    chk("R5", "ipi reject hidden", {31'd0, rejValid}, 32'd0);
    chk("R10", "irq dropped", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic testRaise();
    cmd(2'd2, 32'hFF);
    cmd(2'd1, 32'hFF);
    dlv(24'h77, 8'h07);
    chk("R3", "accepted", {31'd0, dlvAccepted}, 32'd1);
    cmd(2'd1, 32'h07);
    chk("R10", "reject on raise", {31'd0, rejValid}, 32'd1);
    chk("R10", "reject src", {8'd0, rejSrc}, 32'h77);
    chk("R10", "irq low", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic testSameCycle();
    // lower threshold to 0x10 with a delivery at 9: only accepted if the command goes first
    cycle(1'b1, 2'd1, 32'h10, 1'b1, 24'h88, 8'h09);
    chk("R12", "cmd before dlv", {31'd0, dlvAccepted}, 32'd1);
    chk("R2", "irq up", {31'd0, irqOut}, 32'd1);
    cycle(1'b1, 2'd2, 32'h03, 1'b1, 24'h99, 8'h02);
    chk("R12", "mfrr reject", {31'd0, rejValid}, 32'd1);
    chk("R12", "mfrr reject src", {8'd0, rejSrc}, 32'h88);
    chk("R12", "dlv over ipi", {31'd0, dlvAccepted}, 32'd1);
    cmd(2'd0, '0);
    chk("R12", "final word", acceptWord, 32'h1000_0099);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testDeliver();
    testAccept();
    testEoi();
    testIpi();
    testMfrrResend();
    testRaise();
    testSameCycle();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule